// File: doc/BRIEF.md
# Condition Code Evaluator

Every instruction carries a four-bit predicate in bits [31:28] of its 32-bit word. This block takes that word and the four status flags (negative, zero, carry, overflow) and decides whether the instruction may take effect. The pipeline uses the result to squash an instruction whose predicate is false.

The sixteen predicate values form eight pairs. In each pair the odd code is the inverse of the even code. The exception is the last pair: code 1110 always passes, and code 1111 is reserved. A reserved code never passes and raises a separate flag, so that later logic can treat it as an illegal encoding.

The decision is available combinationally. A registered copy is also kept. It is captured together with the instruction as the instruction moves into the execute stage, so execute-stage logic can gate every architectural side effect on a stable flag.

Top module: `cond_eval`

## Requirements
- R1: Only bits [31:28] of the instruction word affect the result. Changing bits [27:0] leaves `condPass` and `neverSeen` unchanged.
- R2: Code 0000 passes when Z=1. Code 0001 passes when Z=0.
- R3: Code 0010 passes when C=1. Code 0011 passes when C=0.
- R4: Code 0100 passes when N=1 and code 0101 passes when N=0. Code 0110 passes when V=1 and code 0111 passes when V=0.
- R5: Code 1000 passes when C=1 and Z=0. Code 1001 passes in every other case.
- R6: Code 1010 passes when N equals V. Code 1011 passes when N differs from V.
- R7: Code 1100 passes when Z=0 and N equals V. Code 1101 passes in every other case.
- R8: For every odd code below 1111, `condPass` is the inverse of the result that the code one lower gives for the same flags.
- R9: Code 1110 passes for all flag values. Code 1111 never passes and sets `neverSeen`. `neverSeen` is 0 for every other code.
- R10: One clock edge after a cycle with `instrValid`=1, `execPass` and `execNever` hold the values that `condPass` and `neverSeen` had in that cycle. After a cycle with `instrValid`=0, both are 0.
- R11: While `rstN` is low, `execPass` and `execNever` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrValid | input | 1 | An instruction enters the execute stage this cycle |
| instrWord | input | 32 | Instruction word; the predicate is in bits [31:28] |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| condPass | output | 1 | Combinational: the predicate holds |
| neverSeen | output | 1 | Combinational: the reserved code 1111 is present |
| execPass | output | 1 | Registered pass flag for the execute-stage instruction |
| execNever | output | 1 | Registered reserved-code flag for the execute-stage instruction |

## Verification
The hardest cases to reach are the compound predicates (higher, greater-than and their inverses). Each of them turns on a single combination of flags, such as C=1 with Z=0, or Z=0 with N equal to V. A few hand-picked flag values can miss the one combination that separates a correct design from a faulty one. The stimulus therefore sweeps all sixteen codes against all sixteen flag combinations, with random filler in the low word bits. It then drives the registered path with a stream in which `instrValid` toggles, so that both capture and clearing are observed.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
  localparam int CODE_W = 4;
  localparam int PAIR_W = CODE_W - 1;

  // strobes from the code decoder to the flag datapath
  typedef struct packed {
    logic [PAIR_W-1:0] pairSel;  // which pair of tests
    logic              invert;   // odd member of the pair
    logic              reserved; // the reserved code
  } condCtrl_t;
endpackage

// File: rtl/cond_eval_ctrl.sv
module cond_eval_ctrl
  import cond_eval_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output condCtrl_t         ctrl
);
  always_comb begin
    ctrl.pairSel  = code[CODE_W-1:1];
    ctrl.reserved = &code;
    // the last pair is not an inverted pair: 1111 is reserved
    ctrl.invert   = code[0] & ~(&code);
  end
endmodule

// File: rtl/cond_eval_dp.sv
module cond_eval_dp
  import cond_eval_pkg::*;
(
  input  condCtrl_t ctrl,
  input  logic      flagN,
  input  logic      flagZ,
  input  logic      flagC,
  input  logic      flagV,
  output logic      pass
);
  localparam int NUM_PAIRS = 1 << PAIR_W;

  logic [NUM_PAIRS-1:0] baseTest;
  logic                 signEq;

  assign signEq = (flagN == flagV);

  generate
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      always_comb begin
        case (p)
          0:       baseTest[p] = flagZ;
          1:       baseTest[p] = flagC;
          2:       baseTest[p] = flagN;
          3:       baseTest[p] = flagV;
          4:       baseTest[p] = flagC & ~flagZ;
          5:       baseTest[p] = signEq;
          6:       baseTest[p] = ~flagZ & signEq;
          default: baseTest[p] = 1'b1;
        endcase
      end
    end
  endgenerate

  always_comb begin
    if (ctrl.reserved) pass = 1'b0;
    else               pass = baseTest[ctrl.pairSel] ^ ctrl.invert;
  end

  // R9: the always pair passes whenever it is not the reserved code
  always_comb begin
    if (ctrl.pairSel == '1 && !ctrl.reserved)
      a_r9_always_passes: assert (pass);
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_eval_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter bit REG_STAGE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  output logic              condPass,
  output logic              neverSeen,
  output logic              execPass,
  output logic              execNever
);
  localparam int CODE_LSB = WORD_W - CODE_W;

  logic [CODE_W-1:0] code;
  condCtrl_t         ctrl;

  assign code      = instrWord[WORD_W-1:CODE_LSB];
  assign neverSeen = ctrl.reserved;

  cond_eval_ctrl i_ctrl (.code(code), .ctrl(ctrl));

  cond_eval_dp i_dp (
    .ctrl(ctrl), .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .pass(condPass)
  );

  generate
    if (REG_STAGE) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          execPass  <= 1'b0;
          execNever <= 1'b0;
        end else begin
          execPass  <= instrValid & condPass;
          execNever <= instrValid & neverSeen;
        end
      end
    end else begin : g_comb
      assign execPass  = instrValid & condPass;
      assign execNever = instrValid & neverSeen;
    end
  endgenerate

  // R9: a reserved code never passes
  a_r9_never_fails: assert property (@(posedge clk) disable iff (!rstN)
    neverSeen |-> !condPass);

  // R2: equal test follows Z
  a_r2_eq_follows_z: assert property (@(posedge clk) disable iff (!rstN)
    (code == 4'b0000) |-> (condPass == flagZ));

  // R6: greater-or-equal follows sign agreement
  a_r6_ge_sign: assert property (@(posedge clk) disable iff (!rstN)
    (code == 4'b1010) |-> (condPass == (flagN == flagV)));

  if (REG_STAGE) begin : g_reg_chk
    // R10: registered flags capture the decision
    a_r10_capture: assert property (@(posedge clk) disable iff (!rstN)
      instrValid |=> (execPass == $past(condPass)) && (execNever == $past(neverSeen)));
    // R10: idle cycle clears both
    a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
      !instrValid |=> !execPass && !execNever);
  end
endmodule

// File: tb/test_cond_eval.sv
module test_cond_eval;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagC = 1'b0, flagV = 1'b0;
  logic        condPass, neverSeen, execPass, execNever;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cond_eval i_cond_eval (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .condPass(condPass), .neverSeen(neverSeen),
    .execPass(execPass), .execNever(execNever)
  );

  function automatic logic refPass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v, b;
    {n, z, cy, v} = f;
    case (c[3:1])
      3'd0: b = z;
      3'd1: b = cy;
      3'd2: b = n;
      3'd3: b = v;
      3'd4: b = cy && !z;
      3'd5: b = (n == v);
      3'd6: b = !z && (n == v);
      default: b = 1'b1;
    endcase
    if (c == 4'hF) return 1'b0;
    if (c == 4'hE) return 1'b1;
    return c[0] ? !b : b;
  endfunction

  function automatic string reqOf(input logic [3:0] c);
    case (c[3:1])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (word %h flags %b%b%b%b)",
               req, act, exp, instrWord, flagN, flagZ, flagC, flagV);
    end
  endtask

  task automatic applyComb(input logic [3:0] c, input logic [3:0] f, input logic [27:0] low);
    @(negedge clk);
    instrWord = {c, low};
    {flagN, flagZ, flagC, flagV} = f;
    #1;
  endtask

  task automatic testReset();
    #1;
    check("R11", execPass, 1'b0);
    check("R11", execNever, 1'b0);
    instrValid = 1'b1;
    instrWord = 32'hE000_0000;
    @(posedge clk); #1;
    check("R11", execPass, 1'b0);
    instrValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testSweep();
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        applyComb(4'(c), 4'(f), 28'($urandom));
        check(reqOf(4'(c)), condPass, refPass(4'(c), 4'(f)));
        check("R9", neverSeen, c == 15);
      end
    end
  endtask

  task automatic testPairInvert();
    for (int c = 0; c < 7; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic evenRes;
        applyComb(4'(2*c), 4'(f), 28'h0);
        evenRes = condPass;
        applyComb(4'(2*c+1), 4'(f), 28'h0);
        check("R8", condPass, !evenRes);
      end
    end
  endtask

  task automatic testLowBits();
    for (int c = 0; c < 16; c++) begin
      logic p0, n0;
      applyComb(4'(c), 4'b0110, 28'h0000000);
      p0 = condPass; n0 = neverSeen;
      applyComb(4'(c), 4'b0110, 28'hFFFFFFF);
      check("R1", condPass, p0);
      check("R1", neverSeen, n0);
      applyComb(4'(c), 4'b0110, 28'h5A5A5A5);
      check("R1", condPass, p0);
    end
  endtask

  task automatic testAlwaysNever();
    for (int f = 0; f < 16; f++) begin
      applyComb(4'hE, 4'(f), 28'($urandom));
      check("R9", condPass, 1'b1);
      applyComb(4'hF, 4'(f), 28'($urandom));
      check("R9", condPass, 1'b0);
      check("R9", neverSeen, 1'b1);
    end
  endtask

  task automatic testRegistered();
    for (int i = 0; i < 64; i++) begin
      logic [3:0] c, f;
      logic v;
      c = 4'($urandom); f = 4'($urandom); v = (i % 3) != 0;
      @(negedge clk);
      instrValid = v;
      instrWord = {c, 28'($urandom)};
      {flagN, flagZ, flagC, flagV} = f;
      @(negedge clk);
      // change inputs so only the captured value can explain the output
      instrValid = 1'b0;
      instrWord = 32'h0000_0000;
      {flagN, flagZ, flagC, flagV} = 4'b0000;
      check("R10", execPass, v & refPass(c, f));
      check("R10", execNever, v & (c == 4'hF));
    end
  endtask

  initial begin
    fork
      begin
        testReset();
        testSweep();
        testPairInvert();
        testLowBits();
        testAlwaysNever();
        testRegistered();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule